// File: doc/BRIEF.md
# Linked-List Sharing Directory Controller

This block sits beside a memory controller and keeps, for every coherently cacheable line it owns, a small directory entry: a two-bit line state and the node address of the cache at the head of that line's sharing list. Caches that share a line are chained to each other. The directory never tracks the whole set of sharers. It only remembers the newest one. Each new requester takes the head position and is told who the previous head was. Walking or purging the rest of the chain is the caches' job.

A request carries an operation code, a line index and the requester's node address. It is accepted in any cycle in which `req_valid` is high, because `req_ready` is held high. In the same clock edge the controller reads the entry, decides the new entry and writes it back. On the following cycle it presents a registered response. The response says where the data comes from, which node was the head before the request, what state the line was in, and whether the requester must purge an existing list. Requests may arrive back to back, including to the same line. Each one sees the entry as left by the request before it.

Top module: `sharing_dir_ctrl`

## Requirements
- R1: After a synchronous active-low reset every line is in state HOME (encoding 00) and `rsp_valid` is low.
- R2: `req_ready` is always high. `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was high, and low otherwise.
- R3: The field codes are as follows. Operations are read-shared 00, read-exclusive 01, DMA-read 10 and DMA-write 11. Line states are HOME 00, FRESH 01 (read-only copies, memory valid) and GONE 10 (head may hold modified data); 11 is never stored. Data sources are memory 00, old head 01 and none 10.
- R4: A read-shared request to a HOME line returns source memory, previous state HOME, head equal to the requester and purge 0. The line becomes FRESH with the requester as head.
- R5: A read-shared request to a FRESH line returns source memory, the old head and purge 0. The line stays FRESH and the requester becomes head.
- R6: A read-shared request to a GONE line returns source old-head, the old head and purge 0. The line stays GONE and the requester becomes head.
- R7: A read-exclusive request leaves the line GONE with the requester as head. It returns source old-head if the line was GONE and memory otherwise. Purge is 1 exactly when the line was not HOME.
- R8: A DMA-read request leaves the entry unchanged and reports purge 0. It returns source old-head if the line is GONE and memory otherwise.
- R9: A DMA-write request returns source none and returns the old head. Purge is 1 exactly when the line was not HOME. The line becomes HOME.
- R10: A request changes only the entry of the line it names.
- R11: In every response, the reported head is the stored head if the previous state was not HOME, and the requester's own address if it was HOME. A request issued in the cycle right after another one to the same line sees that request's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_op | input | 2 | Operation code |
| req_line | input | LINE_W | Directory line index |
| req_node | input | NODE_W | Requester node address |
| rsp_valid | output | 1 | Response present |
| rsp_src | output | 2 | Data source code |
| rsp_head | output | NODE_W | Head before the request |
| rsp_prev_state | output | 2 | Line state before the request |
| rsp_purge | output | 1 | Requester must purge the old list |

## Verification
A wrong entry stays hidden until the next access to that line. That access then shows it at once in `rsp_prev_state`, `rsp_head` and `rsp_src`, one cycle after it is accepted. The bench therefore follows every state-changing request with a DMA-read probe of the same line. This catches a bad update within two cycles. A sweep covers every operation against every starting state on every line. A long pseudo-random stream of back-to-back requests then exposes corruption across lines and read-after-write errors on a single line.

// File: rtl/dir_pkg.sv
// Shared encodings for the sharing-list directory controller.
// Assumes two-bit fields everywhere; the codes are part of the port contract.
package dir_pkg;
    typedef enum logic [1:0] {
        ST_HOME  = 2'b00,
        ST_FRESH = 2'b01,
        ST_GONE  = 2'b10
    } line_state_e;

    typedef enum logic [1:0] {
        OP_RD_SHARED = 2'b00,
        OP_RD_EXCL   = 2'b01,
        OP_DMA_RD    = 2'b10,
        OP_DMA_WR    = 2'b11
    } req_op_e;

    typedef enum logic [1:0] {
        SRC_MEMORY   = 2'b00,
        SRC_OLD_HEAD = 2'b01,
        SRC_NONE     = 2'b10
    } data_src_e;
endpackage

// File: rtl/dir_store.sv
// Directory entry storage: one state and one head pointer per line.
// Combinational read port, single synchronous write port, synchronous
// active-low reset to HOME with a zero head. Assumes the write index and read
// index may be equal; the read returns the value before the edge.
module dir_store #(
    parameter int LINES  = 8,
    parameter int IDX_W  = 3,
    parameter int NODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [1:0]        rd_state,
    output logic [NODE_W-1:0] rd_head,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_state,
    input  logic [NODE_W-1:0] wr_head
);
    logic [1:0]        state_q [LINES];
    logic [NODE_W-1:0] head_q  [LINES];

    // Purpose: reset all entries, else write the addressed entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) begin
                state_q[i] <= 2'b00;
                head_q[i]  <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                state_q[i] <= wr_state;
                head_q[i]  <= wr_head;
            end
        end
    end

    // Purpose: read port for the entry under request.
    always_comb begin
        rd_state = state_q[rd_idx];
        rd_head  = head_q[rd_idx];
    end

    // Per-entry guard: the unused state code must never be stored.
    for (genvar g = 0; g < LINES; g++) begin : g_entry_chk
        assert_legal_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
            state_q[g] != 2'b11);
    end
endmodule

// File: rtl/dir_policy.sv
// Combinational coherence policy: given the operation, the current entry and
// the requester, produce the next entry and the response fields.
// Assumes the entry state is one of the three legal codes.
module dir_policy
    import dir_pkg::*;
#(
    parameter int NODE_W = 4
) (
    input  req_op_e           op,
    input  line_state_e       cur_state,
    input  logic [NODE_W-1:0] cur_head,
    input  logic [NODE_W-1:0] req_node,
    output line_state_e       nxt_state,
    output logic [NODE_W-1:0] nxt_head,
    output logic              wr_needed,
    output data_src_e         src,
    output logic [NODE_W-1:0] old_head,
    output logic              purge
);
    logic listed;

    // Purpose: decide data source, purge need and the new entry.
    always_comb begin
        listed    = (cur_state != ST_HOME);
        old_head  = listed ? cur_head : req_node;
        src       = (cur_state == ST_GONE) ? SRC_OLD_HEAD : SRC_MEMORY;
        purge     = 1'b0;
        nxt_state = cur_state;
        nxt_head  = cur_head;
        wr_needed = 1'b1;
        unique case (op)
            OP_RD_SHARED: begin
                nxt_state = listed ? cur_state : ST_FRESH;
                nxt_head  = req_node;
            end
            OP_RD_EXCL: begin
                nxt_state = ST_GONE;
                nxt_head  = req_node;
                purge     = listed;
            end
            OP_DMA_RD: begin
                wr_needed = 1'b0;
            end
            OP_DMA_WR: begin
                nxt_state = ST_HOME;
                src       = SRC_NONE;
                purge     = listed;
            end
            default: wr_needed = 1'b0;
        endcase
    end
endmodule

// File: rtl/sharing_dir_ctrl.sv
// Memory-side directory controller for linked-list sharing. One
// read-modify-write per accepted request; the response is registered and
// appears the cycle after acceptance. Assumes no back-pressure on responses.
module sharing_dir_ctrl
    import dir_pkg::*;
#(
    parameter int LINE_W = 3,
    parameter int NODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [LINE_W-1:0] req_line,
    input  logic [NODE_W-1:0] req_node,
    output logic              rsp_valid,
    output logic [1:0]        rsp_src,
    output logic [NODE_W-1:0] rsp_head,
    output logic [1:0]        rsp_prev_state,
    output logic              rsp_purge
);
    localparam int LINES = 1 << LINE_W;

    logic              accept;
    logic [1:0]        cur_state_raw;
    logic [NODE_W-1:0] cur_head;
    line_state_e       nxt_state;
    logic [NODE_W-1:0] nxt_head;
    logic              wr_needed;
    data_src_e         src;
    logic [NODE_W-1:0] old_head;
    logic              purge;

    assign req_ready = 1'b1;
    assign accept    = req_valid && req_ready;

    dir_store #(.LINES(LINES), .IDX_W(LINE_W), .NODE_W(NODE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_line),
        .rd_state (cur_state_raw),
        .rd_head  (cur_head),
        .wr_en    (accept && wr_needed),
        .wr_idx   (req_line),
        .wr_state (nxt_state),
        .wr_head  (nxt_head)
    );

    dir_policy #(.NODE_W(NODE_W)) u_policy (
        .op        (req_op_e'(req_op)),
        .cur_state (line_state_e'(cur_state_raw)),
        .cur_head  (cur_head),
        .req_node  (req_node),
        .nxt_state (nxt_state),
        .nxt_head  (nxt_head),
        .wr_needed (wr_needed),
        .src       (src),
        .old_head  (old_head),
        .purge     (purge)
    );

    // Purpose: register the response for the request accepted this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_src        <= 2'b00;
            rsp_head       <= '0;
            rsp_prev_state <= 2'b00;
            rsp_purge      <= 1'b0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_src        <= src;
                rsp_head       <= old_head;
                rsp_prev_state <= cur_state_raw;
                rsp_purge      <= purge;
            end
        end
    end

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);
    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rsp_valid);
    assert_purge_needs_list_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_purge) |-> (rsp_prev_state != 2'b00));
    assert_head_src_gone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_src == 2'b01) |-> (rsp_prev_state == 2'b10));
endmodule

// File: tb/sharing_dir_ctrl_test.sv
// Self-checking bench: full sweep of operation x starting state x line,
// followed by a pseudo-random back-to-back stream, against a bench model.
module sharing_dir_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_W = 3;
    localparam int NODE_W = 4;
    localparam int LINES  = 1 << LINE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = 2'b00;
    logic [LINE_W-1:0] req_line = '0;
    logic [NODE_W-1:0] req_node = '0;
    logic              rsp_valid;
    logic [1:0]        rsp_src;
    logic [NODE_W-1:0] rsp_head;
    logic [1:0]        rsp_prev_state;
    logic              rsp_purge;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [1:0]        m_state [LINES];
    logic [NODE_W-1:0] m_head  [LINES];

    sharing_dir_ctrl #(.LINE_W(LINE_W), .NODE_W(NODE_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_line(req_line), .req_node(req_node),
        .rsp_valid(rsp_valid), .rsp_src(rsp_src), .rsp_head(rsp_head),
        .rsp_prev_state(rsp_prev_state), .rsp_purge(rsp_purge)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Requirement tag covering this op on this starting state.
    function automatic string tag_for(input logic [1:0] op, input logic [1:0] st);
        if (op == 2'b00) return (st == 2'b00) ? "R4" : (st == 2'b01) ? "R5" : "R6";
        if (op == 2'b01) return "R7";
        if (op == 2'b10) return "R8";
        return "R9";
    endfunction

    // Drive one request (caller is at a falling edge); check the response
    // at the next falling edge, one register after acceptance, and update
    // the model. Encodings per R3; head reporting per R11.
    task automatic send(input logic [1:0] op, input int line,
                        input logic [NODE_W-1:0] node, input string extra);
        logic [1:0] st, src_e, nst;
        logic [NODE_W-1:0] hd_e, nhd;
        logic pg_e;
        string tag;
        st   = m_state[line];
        hd_e = (st == 2'b00) ? node : m_head[line];
        src_e = (st == 2'b10) ? 2'b01 : 2'b00;
        pg_e = 1'b0;
        nst = st;
        nhd = m_head[line];
        case (op)
            2'b00: begin nst = (st == 2'b00) ? 2'b01 : st; nhd = node; end
            2'b01: begin nst = 2'b10; nhd = node; pg_e = (st != 2'b00); end
            2'b10: ;
            default: begin nst = 2'b00; src_e = 2'b10; pg_e = (st != 2'b00); end
        endcase
        tag = {tag_for(op, st), extra};
        req_valid = 1'b1;
        req_op    = op;
        req_line  = LINE_W'(line);
        req_node  = node;
        @(negedge clk);
        check(rsp_valid === 1'b1, {tag, "/R2"}, "rsp_valid", 32'(rsp_valid), 1);
        check({rsp_src, rsp_head, rsp_prev_state, rsp_purge} ===
              {src_e, hd_e, st, pg_e}, tag, "src/head/prev/purge",
              32'({rsp_src, rsp_head, rsp_prev_state, rsp_purge}),
              32'({src_e, hd_e, st, pg_e}));
        m_state[line] = nst;
        m_head[line]  = nhd;
    endtask

    task automatic idle_check();
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid === 1'b0, "R2", "rsp_valid idle", 32'(rsp_valid), 0);
        check(req_ready === 1'b1, "R2", "req_ready", 32'(req_ready), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < LINES; i++) begin
            m_state[i] = 2'b00;
            m_head[i]  = '0;
        end
        repeat (3) @(negedge clk);
        check(rsp_valid === 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid), 0);
        rst_n = 1'b1;
        idle_check();

        // R1: every line starts HOME, seen through a DMA-read probe.
        for (int l = 0; l < LINES; l++) send(2'b10, l, NODE_W'(l + 3), "/R1");
        idle_check();

        // Sweep: every op against every starting state on every line, then
        // probe the line (R10 via untouched neighbours checked later).
        for (int l = 0; l < LINES; l++) begin
            for (int s = 0; s < 3; s++) begin
                for (int op = 0; op < 4; op++) begin
                    send(2'b11, l, NODE_W'(1), "");
                    if (s == 1) begin
                        send(2'b00, l, NODE_W'(l + 2), "");
                        send(2'b00, l, NODE_W'(l + 5), "");
                    end else if (s == 2) begin
                        send(2'b01, l, NODE_W'(l + 7), "");
                    end
                    send(2'(op), l, NODE_W'(op * 3 + s + 1), "/R11");
                    send(2'b10, l, NODE_W'(9), "/R10");
                end
            end
            idle_check();
        end

        // Every line keeps what the sweep left there.
        for (int l = 0; l < LINES; l++) send(2'b10, l, NODE_W'(14), "/R10");

        // Pseudo-random back-to-back stream over all lines.
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(lfsr[1:0], int'(lfsr[4:2]), lfsr[8:5], "/R10/R11");
        end
        idle_check();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule